// File: doc/BRIEF.md
# External Interrupt Edge/Level Detector

This block watches eight external interrupt request pins and one non-maskable pin. Each request line latches a status flag whenever the sense condition chosen for it by software occurs: a low level, a falling edge, a rising edge or either edge. The flag stays set until software clears it. A per-line enable decides whether the flag is presented on the line's request output. The non-maskable pin produces a one-cycle request pulse on its selected edge, and no enable or mask inside the block affects it.

Two of the request lines are shared with wider groups. Line 6 also listens to the lower eight key inputs. Line 7 also listens to the upper eight key inputs and to eight wake-up inputs. Every group line has its own mask bit. A high level on any unmasked group line pulls the shared source low, so that group activity looks like a request on that line.

Only some sources may bring the device out of standby. These are the non-maskable pin and request lines 7, 6, 2, 1 and 0. All pins are synchronised before detection. Software reaches the configuration and flags through a simple register write port with a combinational read path.

Top module: `ext_irq_detect`

## Requirements
- R1: Line n's sense mode sits in register 0 at bits [2n+1:2n]. The encodings are 00 = low level, 01 = falling edge, 10 = rising edge and 11 = both edges. The flag sets only when the selected condition occurs.
- R2: Status flags read at register 2, bits [7:0]. Once set, a flag stays set until a write to register 2 with a 1 in its bit position clears it.
- R3: Register 1, bits [7:0], enable the lines. irq_req[n] is high only when flag n and enable n are both set. A flag still sets while its line is disabled.
- R4: In low-level mode the flag sets again on every cycle that the pin stays low. A clear therefore only takes effect after the pin returns high.
- R5: When a set condition and a software clear of the same flag fall in the same cycle, the flag ends set.
- R6: Register 1, bit 8, selects the non-maskable edge: 1 = rising, 0 = falling. Each selected edge gives exactly one single-cycle nmi_req pulse, whatever the enables are.
- R7: Line 6's source is its pin AND NOT(any unmasked key[7:0]). Line 7's source is its pin AND NOT(any unmasked key[15:8] or wake[7:0]). Key masks are in register 3, bits [15:0], and wake masks in register 4, bits [7:0]. A mask bit of 1 means masked.
- R8: wake_o is high when nmi_req is high or when any of irq_req[7], [6], [2], [1] or [0] is high. Lines 5 to 3 never raise it.
- R9: After reset, all modes and enables are 0, every mask bit is 1 and every flag is 0. A pin change applied between clock edges shows in the flag after the third following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq_pin | input | 8 | External interrupt request pins |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| key_pin | input | 16 | Key inputs shared onto lines 6 and 7 |
| wake_pin | input | 8 | Wake-up inputs shared onto line 7 |
| irq_req | output | 8 | Per-line interrupt requests |
| nmi_req | output | 1 | Non-maskable request pulse |
| wake_o | output | 1 | Wake-from-standby indication |

## Verification
The assertions check several properties on every cycle. A flag never drops without a clear write of its bit. A rising or falling-edge flag is only set after the matching transition on its synchronised source. The non-maskable pulse never lasts longer than one cycle. wake_o stays low unless a permitted source is active. Other behaviours only show in the bench's scenarios: the three-edge latency, low-level re-setting against a clear, set-beats-clear in the same cycle, group masking on the shared lines and the exclusion of lines 5 to 3 from wake-up.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    parameter int IRQ_N  = 8;
    parameter int KEY_N  = 16;
    parameter int WAKE_N = 8;
    parameter int SEL_W  = 2;
    parameter int ADDR_W = 3;
    parameter int DATA_W = 16;

    localparam int KEY_HALF = KEY_N / 2;
    localparam int LINE_KEY_LO = 6;
    localparam int LINE_KEY_HI = 7;

    typedef enum logic [SEL_W-1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    localparam logic [ADDR_W-1:0] A_SENSE = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_FLAG  = 3'd2;
    localparam logic [ADDR_W-1:0] A_KMASK = 3'd3;
    localparam logic [ADDR_W-1:0] A_WMASK = 3'd4;

    // Lines allowed to wake the device from standby
    localparam logic [IRQ_N-1:0] WAKE_LINES = 8'b1100_0111;

    typedef struct packed {
        logic [IRQ_N*SEL_W-1:0] sense;
        logic [IRQ_N-1:0]       en;
        logic                   nmi_rise;
        logic [KEY_N-1:0]       kmask;
        logic [WAKE_N-1:0]      wmask;
        logic                   nmi_prev;
        logic                   nmi_pulse;
    } ctl_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= {W{RST_VAL}};
        end else begin
            stg_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line
    import ext_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_i,
    input  logic [SEL_W-1:0] sense_i,
    input  logic             clr_i,
    input  logic             en_i,
    output logic             flag_o,
    output logic             req_o
);
    typedef struct packed {
        logic prev;
        logic flag;
    } line_t;

    line_t st_d, st_q;
    logic  hit;

    always_comb begin
        unique case (sense_e'(sense_i))
            SENSE_LOW:  hit = !src_i;
            SENSE_FALL: hit = st_q.prev && !src_i;
            SENSE_RISE: hit = !st_q.prev && src_i;
            default:    hit = st_q.prev != src_i;
        endcase
        st_d.prev = src_i;
        // a set in the same cycle as a clear wins
        st_d.flag = hit || (st_q.flag && !clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b1;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign req_o  = st_q.flag && en_i;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [IRQ_N-1:0]  irq_pin,
    input  logic              nmi_pin,
    input  logic [KEY_N-1:0]  key_pin,
    input  logic [WAKE_N-1:0] wake_pin,
    output logic [IRQ_N-1:0]  irq_req,
    output logic              nmi_req,
    output logic              wake_o
);
    ctl_t st_d, st_q;

    logic [IRQ_N-1:0]  irq_s;
    logic              nmi_s;
    logic [KEY_N-1:0]  key_s;
    logic [WAKE_N-1:0] wake_s;
    logic [IRQ_N-1:0]  src_w;
    logic [IRQ_N-1:0]  clr_w;
    logic [IRQ_N-1:0]  flag_w;

    ext_irq_sync #(.W(IRQ_N),  .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_irq (
        .clk(clk), .rst_n(rst_n), .din(irq_pin), .dout(irq_s));
    ext_irq_sync #(.W(1),      .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_nmi (
        .clk(clk), .rst_n(rst_n), .din(nmi_pin), .dout(nmi_s));
    ext_irq_sync #(.W(KEY_N),  .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_key (
        .clk(clk), .rst_n(rst_n), .din(key_pin), .dout(key_s));
    ext_irq_sync #(.W(WAKE_N), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_wake (
        .clk(clk), .rst_n(rst_n), .din(wake_pin), .dout(wake_s));

    // Shared sources: any unmasked high group line pulls the line low
    always_comb begin
        src_w = irq_s;
        src_w[LINE_KEY_LO] = irq_s[LINE_KEY_LO]
                           && !(|(key_s[KEY_HALF-1:0] & ~st_q.kmask[KEY_HALF-1:0]));
        src_w[LINE_KEY_HI] = irq_s[LINE_KEY_HI]
                           && !(|(key_s[KEY_N-1:KEY_HALF] & ~st_q.kmask[KEY_N-1:KEY_HALF]))
                           && !(|(wake_s & ~st_q.wmask));
    end

    assign clr_w = (reg_we && reg_addr == A_FLAG) ? reg_wdata[IRQ_N-1:0] : '0;

    for (genvar i = 0; i < IRQ_N; i++) begin : g_line
        ext_irq_line u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_w[i]),
            .sense_i(st_q.sense[i*SEL_W +: SEL_W]),
            .clr_i  (clr_w[i]),
            .en_i   (st_q.en[i]),
            .flag_o (flag_w[i]),
            .req_o  (irq_req[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            unique case (reg_addr)
                A_SENSE: st_d.sense = reg_wdata[IRQ_N*SEL_W-1:0];
                A_CTRL: begin
                    st_d.en       = reg_wdata[IRQ_N-1:0];
                    st_d.nmi_rise = reg_wdata[IRQ_N];
                end
                A_KMASK: st_d.kmask = reg_wdata[KEY_N-1:0];
                A_WMASK: st_d.wmask = reg_wdata[WAKE_N-1:0];
                default: ;
            endcase
        end
        st_d.nmi_prev  = nmi_s;
        st_d.nmi_pulse = st_q.nmi_rise ? (nmi_s && !st_q.nmi_prev)
                                       : (!nmi_s && st_q.nmi_prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sense     <= '0;
            st_q.en        <= '0;
            st_q.nmi_rise  <= 1'b0;
            st_q.kmask     <= '1;
            st_q.wmask     <= '1;
            st_q.nmi_prev  <= 1'b1;
            st_q.nmi_pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_SENSE: reg_rdata[IRQ_N*SEL_W-1:0] = st_q.sense;
            A_CTRL: begin
                reg_rdata[IRQ_N-1:0] = st_q.en;
                reg_rdata[IRQ_N]     = st_q.nmi_rise;
            end
            A_FLAG:  reg_rdata[IRQ_N-1:0]  = flag_w;
            A_KMASK: reg_rdata[KEY_N-1:0]  = st_q.kmask;
            A_WMASK: reg_rdata[WAKE_N-1:0] = st_q.wmask;
            default: ;
        endcase
    end

    assign nmi_req = st_q.nmi_pulse;
    assign wake_o  = st_q.nmi_pulse || (|(irq_req & WAKE_LINES));
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk
    import ext_irq_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_we,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic [DATA_W-1:0]      reg_wdata,
    input logic [IRQ_N-1:0]       flag,
    input logic [IRQ_N-1:0]       src,
    input logic [IRQ_N*SEL_W-1:0] sense,
    input logic [IRQ_N-1:0]       irq_req,
    input logic                   nmi_req,
    input logic                   wake_o
);
    logic [IRQ_N-1:0] clr_seen;
    assign clr_seen = (reg_we && reg_addr == A_FLAG) ? reg_wdata[IRQ_N-1:0] : '0;

    // R2: a flag only falls after a clear write to its bit
    a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flag) & ~$past(clr_seen) & ~flag) == '0));

    // R6: the non-maskable request is a single-cycle pulse
    a_r6_nmi_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);

    // R8: no wake indication without a permitted source
    a_r8_wake_sources: assert property (@(posedge clk) disable iff (!rst_n)
        (((irq_req & WAKE_LINES) == '0) && !nmi_req) |-> !wake_o);

    a_r8_nmi_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> wake_o);

    for (genvar i = 0; i < IRQ_N; i++) begin : g_chk
        // R1: edge-mode flags need the matching source transition
        a_r1_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(flag[i]) && $past(sense[i*SEL_W +: SEL_W]) == SENSE_RISE)
            |-> ($past(src[i]) && !$past(src[i], 2)));

        a_r1_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(flag[i]) && $past(sense[i*SEL_W +: SEL_W]) == SENSE_FALL)
            |-> (!$past(src[i]) && $past(src[i], 2)));
    end
endmodule

bind ext_irq_detect ext_irq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .flag     (flag_w),
    .src      (src_w),
    .sense    (st_q.sense),
    .irq_req  (irq_req),
    .nmi_req  (nmi_req),
    .wake_o   (wake_o)
);

// File: tb/ext_irq_detect_tb.sv
`timescale 1ns/1ps
module ext_irq_detect_tb;
    import ext_irq_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n;
    logic              reg_we;
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] reg_wdata;
    logic [DATA_W-1:0] reg_rdata;
    logic [IRQ_N-1:0]  irq_pin;
    logic              nmi_pin;
    logic [KEY_N-1:0]  key_pin;
    logic [WAKE_N-1:0] wake_pin;
    logic [IRQ_N-1:0]  irq_req;
    logic              nmi_req;
    logic              wake_o;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    ext_irq_detect u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pin(irq_pin),
        .nmi_pin(nmi_pin), .key_pin(key_pin), .wake_pin(wake_pin),
        .irq_req(irq_req), .nmi_req(nmi_req), .wake_o(wake_o));

    // {mode[4:3], level before[2], level after[1], flag expected[0]}
    localparam logic [4:0] VEC [8] = '{
        {2'b00, 1'b1, 1'b0, 1'b1},
        {2'b00, 1'b1, 1'b1, 1'b0},
        {2'b01, 1'b1, 1'b0, 1'b1},
        {2'b01, 1'b0, 1'b1, 1'b0},
        {2'b10, 1'b0, 1'b1, 1'b1},
        {2'b10, 1'b1, 1'b0, 1'b0},
        {2'b11, 1'b1, 1'b0, 1'b1},
        {2'b11, 1'b0, 1'b1, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cyc(1);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp);
        reg_addr = a;
        #0.5;
        check(tag, reg_rdata, exp);
    endtask

    task automatic flag_chk(input string tag, input int bitn, input logic exp);
        reg_addr = A_FLAG;
        #0.5;
        check(tag, reg_rdata[bitn], exp);
    endtask

    task automatic count_nmi(input int n, output int pulses, output bit woke);
        pulses = 0; woke = 0;
        repeat (n) begin
            cyc(1);
            if (nmi_req) begin
                pulses++;
                if (wake_o) woke = 1;
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int  p;
        bit  w;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        irq_pin = '1; nmi_pin = 1'b1; key_pin = '0; wake_pin = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // R9 reset state
        rd_chk("R9 sense reset", A_SENSE, 16'h0000);
        rd_chk("R9 ctrl reset",  A_CTRL,  16'h0000);
        rd_chk("R9 flag reset",  A_FLAG,  16'h0000);
        rd_chk("R9 kmask reset", A_KMASK, 16'hFFFF);
        rd_chk("R9 wmask reset", A_WMASK, 16'h00FF);
        check("R9 irq_req reset", irq_req, 0);
        check("R9 nmi_req reset", nmi_req, 0);
        check("R9 wake_o reset",  wake_o, 0);

        // R1 mode table on line 2
        for (int k = 0; k < 8; k++) begin
            irq_pin[2] = VEC[k][2];
            wr(A_SENSE, {10'b0, VEC[k][4:3], 4'b0});
            cyc(4);
            wr(A_FLAG, 16'h0004);
            cyc(1);
            irq_pin[2] = VEC[k][1];
            cyc(4);
            flag_chk($sformatf("R1 mode %0d vector %0d", VEC[k][4:3], k), 2, VEC[k][0]);
        end
        irq_pin[2] = 1'b1;
        wr(A_SENSE, 16'h0000);
        cyc(4);
        wr(A_FLAG, 16'h00FF);

        // R9 latency, line 0 falling
        wr(A_SENSE, 16'h0001);
        cyc(2);
        irq_pin[0] = 1'b0;
        cyc(2);
        flag_chk("R9 not yet after two edges", 0, 1'b0);
        cyc(1);
        flag_chk("R9 set after three edges", 0, 1'b1);
        check("R3 disabled line no request", irq_req, 8'h00);
        wr(A_CTRL, 16'h0001);
        check("R3 enabled line requests", irq_req, 8'h01);
        check("R8 line 0 wakes", wake_o, 1'b1);
        irq_pin[0] = 1'b1;
        cyc(4);
        flag_chk("R2 flag sticky", 0, 1'b1);
        wr(A_FLAG, 16'h0001);
        flag_chk("R2 flag cleared", 0, 1'b0);
        check("R2 request gone after clear", irq_req, 8'h00);

        // R8 line 4 cannot wake
        wr(A_SENSE, 16'h0101);
        wr(A_CTRL, 16'h0010);
        irq_pin[4] = 1'b0;
        cyc(4);
        check("R8 line 4 requests", irq_req, 8'h10);
        check("R8 line 4 no wake", wake_o, 1'b0);
        irq_pin[4] = 1'b1;
        wr(A_CTRL, 16'h0000);
        cyc(4);
        wr(A_FLAG, 16'h00FF);

        // R4 low-level re-set on line 1
        wr(A_SENSE, 16'h0000);
        irq_pin[1] = 1'b0;
        cyc(4);
        wr(A_FLAG, 16'h0002);
        flag_chk("R4 clear ineffective while low", 1, 1'b1);
        irq_pin[1] = 1'b1;
        cyc(4);
        wr(A_FLAG, 16'h0002);
        flag_chk("R4 clear effective after high", 1, 1'b0);

        // R5 set beats clear on line 3, both edges
        wr(A_SENSE, 16'h00C0);
        irq_pin[3] = 1'b0;
        cyc(4);
        flag_chk("R5 first edge sets", 3, 1'b1);
        irq_pin[3] = 1'b1;
        cyc(2);
        reg_we = 1'b1; reg_addr = A_FLAG; reg_wdata = 16'h0008;
        cyc(1);
        reg_we = 1'b0;
        flag_chk("R5 set wins over clear", 3, 1'b1);
        cyc(2);
        wr(A_FLAG, 16'h0008);
        flag_chk("R2 clear without event", 3, 1'b0);
        wr(A_SENSE, 16'h0000);

        // R6 non-maskable edges, enables all zero
        wr(A_CTRL, 16'h0000);
        nmi_pin = 1'b0;
        count_nmi(6, p, w);
        check("R6 falling gives one pulse", p, 1);
        check("R8 nmi wakes", w, 1'b1);
        nmi_pin = 1'b1;
        count_nmi(6, p, w);
        check("R6 rise ignored in falling mode", p, 0);
        wr(A_CTRL, 16'h0100);
        nmi_pin = 1'b0;
        count_nmi(6, p, w);
        check("R6 fall ignored in rising mode", p, 0);
        nmi_pin = 1'b1;
        count_nmi(6, p, w);
        check("R6 rising gives one pulse", p, 1);

        // R7 shared sources on lines 6 and 7, falling mode
        wr(A_CTRL, 16'h0000);
        wr(A_SENSE, 16'h5000);
        cyc(2);
        wr(A_FLAG, 16'h00FF);
        key_pin[3] = 1'b1;
        cyc(5);
        flag_chk("R7 masked key ignored", 6, 1'b0);
        key_pin[3] = 1'b0;
        cyc(4);
        wr(A_KMASK, 16'hFFF7);
        key_pin[3] = 1'b1;
        cyc(4);
        flag_chk("R7 unmasked key sets line 6", 6, 1'b1);
        flag_chk("R7 line 7 untouched by low keys", 7, 1'b0);
        wake_pin[5] = 1'b1;
        cyc(5);
        flag_chk("R7 masked wake ignored", 7, 1'b0);
        wake_pin[5] = 1'b0;
        cyc(4);
        wr(A_WMASK, 16'h00DF);
        wake_pin[5] = 1'b1;
        cyc(4);
        flag_chk("R7 unmasked wake sets line 7", 7, 1'b1);
        wr(A_CTRL, 16'h0040);
        check("R8 line 6 wakes", wake_o, 1'b1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule